// File: doc/BRIEF.md
# Write Burst Strobe and Data Launcher

This block produces the strobe, complementary strobe, data and byte-mask drive values for DDR2 write bursts, along with the output enables for each of them. It runs on a step clock whose period is half a memory clock, so every output value describes one half cycle of the memory clock. A write command arrives on a valid/ready interface and carries its data, its masks and a copy of the mode settings: write latency, burst length and complementary-strobe enable.

The strobe enable rises a programmed write latency after the command is accepted. The strobe is driven low for one preamble step and then toggles. Each data beat goes out on the step of its strobe edge. A separate lag flag tells the pad stage to place that beat a quarter clock after the edge. The data enable drops after the last beat, and the strobe enable is held for one more step.

The block holds one command in a waiting slot while a burst is in flight. The ready signal stays low while that slot is occupied. A command that is due before the running burst can make room is held back. It then starts where the running burst would have begun its final strobe step, so the two bursts join with no gap in the strobe enable.

Top module: `wr_strobe_launcher`

## Requirements
- R1: During and straight after reset, all enables, `busy` and all value outputs are 0, and `cmd_ready` is 1.
- R2: With a write-latency code WL (a code of 0 is taken as 1), the strobe enable of an unqueued command rises in the output step that follows the step-clock edge 2*WL after the edge that accepted the command.
- R3: A burst of BL beats drives the strobe enable for BL+1 consecutive steps. On step k the strobe value is k mod 2, so the first step is a low preamble.
- R4: On steps 0..BL-1, `dq` carries `stage_data[k*DQ_W +: DQ_W]` and `dm` carries `stage_mask[k*MASK_W +: MASK_W]`, with `dq_oe` and `dm_oe` high. Mask bit j covers byte lane j of `dq`. On step BL both enables are low while the strobe enable stays high.
- R5: `dq_lag` is high exactly on steps that carry a data beat. It marks those beats for launch a quarter clock after that step's strobe edge.
- R6: When the command's complementary-strobe enable is 1, `dqsn_oe` follows `dqs_oe` and `dqsn` is the inverse of `dqs`. When the enable is 0, `dqsn_oe` stays 0.
- R7: `mode_long_burst` = 1 selects BL = MAX_BEATS (8). A value of 0 selects BL = MAX_BEATS/2 (4).
- R8: Data, mask and mode inputs are sampled only on the accepting edge. Later changes on those inputs do not alter a burst that is waiting or in flight.
- R9: A command is accepted on a step-clock edge where `cmd_valid` and `cmd_ready` are both 1. `cmd_ready` is 0 from the accepting edge until that command launches. The source must hold its command stable while `cmd_ready` is 0.
- R10: A waiting command launches on the later of two edges: the edge its latency expires, and the edge L+BL (L being the launch edge of the preceding burst). A command launched on edge L+BL replaces that burst's final strobe step with its own preamble.
- R11: `dq`, `dm`, `dqs` and `dqsn` read 0 in any step where their own enable is 0.
- R12: `busy` is 1 whenever a command is waiting or a burst is in flight, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Step clock, one edge per memory half cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Write command offered |
| cmd_ready | output | 1 | Waiting slot free; command taken on valid and ready |
| mode_wl | input | WL_W | Write latency in memory clocks (0 treated as 1) |
| mode_long_burst | input | 1 | 1 = MAX_BEATS beats, 0 = half that |
| mode_strobe_n_en | input | 1 | Enable complementary strobe drive |
| stage_data | input | MAX_BEATS*DQ_W | Packed beats, beat k in slice k |
| stage_mask | input | MAX_BEATS*DQ_W/8 | Packed byte masks, beat k in slice k |
| busy | output | 1 | Command waiting or burst in flight |
| dqs_oe | output | 1 | Strobe output enable |
| dqs | output | 1 | Strobe value for this step |
| dqsn_oe | output | 1 | Complementary strobe enable |
| dqsn | output | 1 | Complementary strobe value |
| dq_oe | output | 1 | Data enable |
| dq | output | DQ_W | Data beat for this step |
| dm_oe | output | 1 | Mask enable |
| dm | output | DQ_W/8 | Byte mask for this step |
| dq_lag | output | 1 | Data to be launched a quarter clock after this step's strobe edge |

## Verification
The hardest case to reach is a waiting command whose latency expires while the previous burst is still mid-flight. The launch must then be held back to edge L+BL, and the joined bursts must show no gap in the strobe enable. The stimulus offers commands back to back most of the time with short, random latency codes, including code 0, and mixes the two burst lengths. This makes new commands fall due both before and after the chaining point. While no command is offered, the data and mode inputs change every cycle, so any sampling outside the accepting edge shows up as wrong beats.

// File: rtl/wrb_pkg.sv
package wrb_pkg;
  // settings captured with each write command
  typedef struct packed {
    logic long_burst;
    logic strobe_n_en;
  } wr_mode_t;
endpackage

// File: rtl/wrb_launch_slot.sv
module wrb_launch_slot
  import wrb_pkg::*;
#(
  parameter int WL_W   = 3,
  parameter int DATA_W = 128,
  parameter int MASK_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              take,
  input  logic [WL_W-1:0]   wl_in,
  input  wr_mode_t          mode_in,
  input  logic [DATA_W-1:0] data_in,
  input  logic [MASK_W-1:0] mask_in,
  output logic              held,
  output logic              due,
  output wr_mode_t          mode_out,
  output logic [DATA_W-1:0] data_out,
  output logic [MASK_W-1:0] mask_out
);
  localparam int CNT_W = WL_W + 1;

  logic [CNT_W-1:0] cnt;
  logic [WL_W-1:0]  wl_eff;

  always_comb wl_eff = (wl_in == '0) ? WL_W'(1) : wl_in;

  // countdown in step units (two per memory clock), saturating at 1 = due
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held     <= 1'b0;
      cnt      <= '0;
      mode_out <= '0;
      data_out <= '0;
      mask_out <= '0;
    end else if (accept) begin
      held     <= 1'b1;
      cnt      <= {wl_eff, 1'b0};
      mode_out <= mode_in;
      data_out <= data_in;
      mask_out <= mask_in;
    end else if (take) begin
      held <= 1'b0;
    end else if (held && cnt != CNT_W'(1)) begin
      cnt <= cnt - 1'b1;
    end
  end

  always_comb due = held && (cnt == CNT_W'(1));

  a_r2_countdown: assert property (@(posedge clk) disable iff (!rst_n)
    (held && cnt > CNT_W'(1)) |=> (cnt == $past(cnt) - 1'b1));

  a_r9_kept_until_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (held && !take) |=> held);

  a_r10_take_only_when_due: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> due);
endmodule

// File: rtl/wrb_burst_seq.sv
module wrb_burst_seq
  import wrb_pkg::*;
#(
  parameter int DQ_W      = 16,
  parameter int MAX_BEATS = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  input  wr_mode_t                      mode_in,
  input  logic [MAX_BEATS*DQ_W-1:0]     data_in,
  input  logic [MAX_BEATS*DQ_W/8-1:0]   mask_in,
  output logic                          active,
  output logic                          chain_ok,
  output logic                          dqs_oe,
  output logic                          dqs,
  output logic                          dqsn_oe,
  output logic                          dqsn,
  output logic                          dq_oe,
  output logic [DQ_W-1:0]               dq,
  output logic [DQ_W/8-1:0]             dm,
  output logic                          dq_lag
);
  localparam int MASK_W = DQ_W / 8;
  localparam int STEP_W = $clog2(MAX_BEATS + 1);
  localparam int IDX_W  = $clog2(MAX_BEATS);

  logic [STEP_W-1:0]           step;
  logic [STEP_W-1:0]           last;
  wr_mode_t                    mode_r;
  logic [MAX_BEATS*DQ_W-1:0]   data_r;
  logic [MAX_BEATS*MASK_W-1:0] mask_r;
  logic [DQ_W-1:0]             beat_d [MAX_BEATS];
  logic [MASK_W-1:0]           beat_m [MAX_BEATS];
  logic [IDX_W-1:0]            idx;

  for (genvar g = 0; g < MAX_BEATS; g++) begin : g_unpack
    assign beat_d[g] = data_r[g*DQ_W +: DQ_W];
    assign beat_m[g] = mask_r[g*MASK_W +: MASK_W];
  end

  always_comb begin
    last     = mode_r.long_burst ? STEP_W'(MAX_BEATS) : STEP_W'(MAX_BEATS / 2);
    chain_ok = !active || (step >= last - 1'b1);
    idx      = step[IDX_W-1:0];
  end

  // step 0 = preamble, steps 0..last-1 carry beats, step last = postamble
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      step   <= '0;
      mode_r <= '0;
      data_r <= '0;
      mask_r <= '0;
    end else if (start) begin
      active <= 1'b1;
      step   <= '0;
      mode_r <= mode_in;
      data_r <= data_in;
      mask_r <= mask_in;
    end else if (active) begin
      if (step == last) active <= 1'b0;
      else              step   <= step + 1'b1;
    end
  end

  always_comb begin
    dqs_oe  = active;
    dqs     = active & step[0];
    dqsn_oe = active & mode_r.strobe_n_en;
    dqsn    = dqsn_oe & ~step[0];
    dq_oe   = active && (step < last);
    dq_lag  = dq_oe;
    dq      = dq_oe ? beat_d[idx] : '0;
    dm      = dq_oe ? beat_m[idx] : '0;
  end

  a_r3_step_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !start && step != last) |=> (active && step == $past(step) + 1'b1));

  a_r10_chain_point: assert property (@(posedge clk) disable iff (!rst_n)
    (start && active) |-> (step >= last - 1'b1));

  a_r7_length_bound: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (step <= last));
endmodule

// File: rtl/wr_strobe_launcher.sv
module wr_strobe_launcher
  import wrb_pkg::*;
#(
  parameter int DQ_W      = 16,
  parameter int MAX_BEATS = 8,
  parameter int WL_W      = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cmd_valid,
  output logic                        cmd_ready,
  input  logic [WL_W-1:0]             mode_wl,
  input  logic                        mode_long_burst,
  input  logic                        mode_strobe_n_en,
  input  logic [MAX_BEATS*DQ_W-1:0]   stage_data,
  input  logic [MAX_BEATS*DQ_W/8-1:0] stage_mask,
  output logic                        busy,
  output logic                        dqs_oe,
  output logic                        dqs,
  output logic                        dqsn_oe,
  output logic                        dqsn,
  output logic                        dq_oe,
  output logic [DQ_W-1:0]             dq,
  output logic                        dm_oe,
  output logic [DQ_W/8-1:0]           dm,
  output logic                        dq_lag
);
  localparam int MASK_W = DQ_W / 8;
  localparam int DATA_W = MAX_BEATS * DQ_W;
  localparam int MSKS_W = MAX_BEATS * MASK_W;

  logic                accept, take, held, due, active, chain_ok;
  wr_mode_t            mode_in, slot_mode;
  logic [DATA_W-1:0]   slot_data;
  logic [MSKS_W-1:0]   slot_mask;

  always_comb begin
    mode_in.long_burst  = mode_long_burst;
    mode_in.strobe_n_en = mode_strobe_n_en;
    cmd_ready = !held;
    accept    = cmd_valid && !held;
    take      = due && chain_ok;
    busy      = held || active;
    dm_oe     = dq_oe;
  end

  wrb_launch_slot #(.WL_W(WL_W), .DATA_W(DATA_W), .MASK_W(MSKS_W)) u_slot (
    .clk(clk), .rst_n(rst_n), .accept(accept), .take(take),
    .wl_in(mode_wl), .mode_in(mode_in), .data_in(stage_data), .mask_in(stage_mask),
    .held(held), .due(due), .mode_out(slot_mode), .data_out(slot_data), .mask_out(slot_mask)
  );

  wrb_burst_seq #(.DQ_W(DQ_W), .MAX_BEATS(MAX_BEATS)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(take), .mode_in(slot_mode),
    .data_in(slot_data), .mask_in(slot_mask), .active(active), .chain_ok(chain_ok),
    .dqs_oe(dqs_oe), .dqs(dqs), .dqsn_oe(dqsn_oe), .dqsn(dqsn),
    .dq_oe(dq_oe), .dq(dq), .dm(dm), .dq_lag(dq_lag)
  );

  a_r4_data_inside_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> dqs_oe);

  a_r6_complement: assert property (@(posedge clk) disable iff (!rst_n)
    dqsn_oe |-> (dqs_oe && dqsn != dqs));

  a_r12_stall_is_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> busy);
endmodule

// File: tb/wr_strobe_launcher_test.sv
`timescale 1ns/1ps
module wr_strobe_launcher_test;
  localparam int DQ_W = 16, MB = 8, WL_W = 3, MW = DQ_W/8;
  localparam int NCYC = 4000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid, cmd_ready, busy;
  logic [WL_W-1:0] mode_wl;
  logic mode_long_burst, mode_strobe_n_en;
  logic [MB*DQ_W-1:0] stage_data;
  logic [MB*MW-1:0] stage_mask;
  logic dqs_oe, dqs, dqsn_oe, dqsn, dq_oe, dm_oe, dq_lag;
  logic [DQ_W-1:0] dq;
  logic [MW-1:0] dm;

  int total = 0, bad = 0;

  always #4 clk = ~clk;

  wr_strobe_launcher #(.DQ_W(DQ_W), .MAX_BEATS(MB), .WL_W(WL_W)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .mode_wl(mode_wl), .mode_long_burst(mode_long_burst), .mode_strobe_n_en(mode_strobe_n_en),
    .stage_data(stage_data), .stage_mask(stage_mask), .busy(busy),
    .dqs_oe(dqs_oe), .dqs(dqs), .dqsn_oe(dqsn_oe), .dqsn(dqsn),
    .dq_oe(dq_oe), .dq(dq), .dm_oe(dm_oe), .dm(dm), .dq_lag(dq_lag)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int burst_len(input logic lng);
    return lng ? MB : MB/2;
  endfunction

  function automatic int eff_wl(input logic [WL_W-1:0] w);
    return (w == 0) ? 1 : int'(w);
  endfunction

  // bench model state
  int edge_n = 0;
  int cur_l = -1000, cur_bl = 4, p_launch = 0;
  bit pending = 0, cur_sn = 0, p_sn = 0;
  int p_bl = 4;
  logic [MB*DQ_W-1:0] cur_d = '0, p_d = '0;
  logic [MB*MW-1:0] cur_m = '0, p_m = '0;
  int ncmd = 0;

  task automatic new_fields();
    mode_wl          = WL_W'($urandom_range(0, 7));
    mode_long_burst  = $urandom_range(0, 1);
    mode_strobe_n_en = $urandom_range(0, 1);
    for (int i = 0; i < MB*DQ_W/32; i++) stage_data[i*32 +: 32] = $urandom;
    stage_mask = (MB*MW)'($urandom);
  endtask

  task automatic check_outputs();
    int k;
    bit on, d_on, e_sn;
    logic [DQ_W-1:0] e_dq;
    logic [MW-1:0] e_dm;
    k    = edge_n - cur_l;
    on   = (k >= 0) && (k <= cur_bl);
    d_on = on && (k < cur_bl);
    e_sn = on && cur_sn;
    e_dq = d_on ? cur_d[k*DQ_W +: DQ_W] : '0;
    e_dm = d_on ? cur_m[k*MW +: MW] : '0;
    chk(dqs_oe == on, "R2 R3", "dqs_oe", 32'(dqs_oe), 32'(on));
    chk(dqs == (on && k[0]), "R3 R11", "dqs", 32'(dqs), 32'(on && k[0]));
    chk(dq_oe == d_on && dm_oe == d_on, "R4 R7", "dq_oe/dm_oe", {dq_oe, dm_oe}, {d_on, d_on});
    chk(dq == e_dq, "R4 R8 R11", "dq", 32'(dq), 32'(e_dq));
    chk(dm == e_dm, "R4 R8 R11", "dm", 32'(dm), 32'(e_dm));
    chk(dq_lag == d_on, "R5", "dq_lag", 32'(dq_lag), 32'(d_on));
    chk(dqsn_oe == e_sn, "R6 R8", "dqsn_oe", 32'(dqsn_oe), 32'(e_sn));
    chk(dqsn == (e_sn && !k[0]), "R6 R11", "dqsn", 32'(dqsn), 32'(e_sn && !k[0]));
    chk(cmd_ready == !pending, "R9 R10", "cmd_ready", 32'(cmd_ready), 32'(!pending));
    chk(busy == (pending || on), "R12", "busy", 32'(busy), 32'(pending || on));
  endtask

  initial begin
    cmd_valid = 1'b0;
    new_fields();
    // R1: reset state
    repeat (3) begin
      @(negedge clk);
      chk(!dqs_oe && !dqsn_oe && !dq_oe && !dm_oe && !dq_lag && !busy, "R1", "enables/busy",
          {dqs_oe, dqsn_oe, dq_oe, dm_oe, dq_lag, busy}, 0);
      chk(dq == 0 && dm == 0 && !dqs && !dqsn && cmd_ready, "R1", "values/ready",
          {dq, dm, dqs, dqsn, cmd_ready}, 1);
    end
    rst_n = 1'b1;
    // first command, directed: latency code 0, short burst
    cmd_valid = 1'b1;
    mode_wl = '0; mode_long_burst = 1'b0; mode_strobe_n_en = 1'b1;
    for (int c = 0; c < NCYC; c++) begin
      bit acc;
      @(posedge clk);
      edge_n++;
      acc = cmd_valid && !pending;
      if (pending && edge_n == p_launch) begin
        cur_l = edge_n; cur_bl = p_bl; cur_d = p_d; cur_m = p_m; cur_sn = p_sn;
        pending = 0;
      end
      if (acc) begin
        int a, b;
        a = edge_n + 2*eff_wl(mode_wl);
        b = cur_l + cur_bl;
        p_launch = (a > b) ? a : b;
        p_bl = burst_len(mode_long_burst);
        p_d = stage_data; p_m = stage_mask; p_sn = mode_strobe_n_en;
        pending = 1;
        ncmd++;
      end
      @(negedge clk);
      check_outputs();
      // next stimulus: hold while stalled, else pick new
      if (cmd_valid && !acc) begin
        // hold command stable
      end else if (ncmd < 4) begin
        // directed: long bursts with latency 1, offered back to back
        cmd_valid = 1'b1;
        new_fields();
        mode_wl = WL_W'(1); mode_long_burst = 1'b1;
      end else begin
        cmd_valid = ($urandom_range(0, 3) != 0);
        new_fields();
        if ($urandom_range(0, 3) == 0) mode_wl = WL_W'($urandom_range(0, 1));
      end
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    process::self().srandom(32'd1234);
  end

  initial begin
    #(8 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule